// File: doc/BRIEF.md
# Split-Screen Pixel-Pair Timing Generator

This block generates the raster timing for one half of a panel whose screen is split into a left and a right half. Each half is fed over its own channel. Each clock carries two horizontally adjacent pixels: an even pixel and the odd pixel to its right. With the default sizes, a half-screen line has 512 active clocks (1024 pixels) and a frame has 1536 active lines. Both halves run from one clock source, so two instances of this block stay locked when they are reset together.

A horizontal counter and a vertical counter each walk through four segments in a fixed order: front porch, sync, back porch, then active. The widths of the porches and of the syncs come from input pins. A shadow register takes a copy of these widths, the two sync polarities and the half-select bit once per frame, on the last clock of the frame. A width set that breaks the legal ranges is replaced by the built-in default set for that axis. The vertical sync register is updated at only one point in each line, a fixed number of clocks after the horizontal sync leading edge. Because of this, vertical sync never toggles close to that edge.

The outputs are horizontal and vertical sync at their programmed polarity, an active-high display-enable, the pixel-pair column, the active line number, the absolute index of the even pixel and the half flag.

Top module: `halfscreen_timing`

## Requirements
- R1: A synchronous active-high reset puts both counters at the first clock of the vertical front porch, and the first frame after reset uses the default widths. In the first cycle after reset, the outputs read de=0, col=0, line=0, pix=0, right=0, hsync=0 and vsync=0. The defaults are positive polarity and the left half.
- R2: A line is FP clocks of front porch, then HS clocks of sync (hsync at active level), then BP clocks of back porch, then HACT clocks of active pixel pairs. The line total is FP+HS+BP+HACT.
- R3: A frame is VFP lines of front porch, then VS sync lines, then VBP lines of back porch, then VACT active lines. Display-enable is high only on an active clock of an active line.
- R4: While display-enable is high, col counts 0..HACT-1 along the line and line counts 0..VACT-1 down the frame. Both read 0 while display-enable is low.
- R5: The half flag equals the sampled half-select bit (1 = right half). While display-enable is high, pix = right*2*HACT + 2*col. pix reads 0 otherwise.
- R6: A sampled polarity bit of 1 makes a sync high at its active level. A polarity bit of 0 inverts that sync.
- R7: All configuration inputs are sampled only on the last clock of a frame. A change at any other time has no effect until the next frame.
- R8: A horizontal set is legal only if every field is at least 1, FP+HS+BP lies in [HBLANK_MIN, HBLANK_MAX], the line total lies in [HTOTAL_MIN, HTOTAL_MAX] and FP+VS_ALIGN is less than the line total. An illegal set is replaced by the default horizontal widths, while the vertical widths and polarities are still taken from the inputs.
- R9: A vertical set is legal only if every field is at least 1 and VFP+VS+VBP lies in [VBLANK_MIN, VBLANK_MAX]. An illegal set is replaced by the default vertical widths.
- R10: vsync changes only in the clock that comes exactly VS_ALIGN clocks after the hsync leading edge (default 16). It therefore never changes within VS_GUARD clocks (default 6) on either side of that edge. The sync state applied is the state of the line in progress at that point.
- R11: The default timing is 12/68/80 clocks of front porch, sync and back porch with 512 active clocks (672 per line), and 6/12/58 lines with 1536 active lines (1612 per frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hfp_i | input | TG_CW | Horizontal front porch, clocks |
| cfg_hsw_i | input | TG_CW | Horizontal sync width, clocks |
| cfg_hbp_i | input | TG_CW | Horizontal back porch, clocks |
| cfg_vfp_i | input | TG_CW | Vertical front porch, lines |
| cfg_vsw_i | input | TG_CW | Vertical sync width, lines |
| cfg_vbp_i | input | TG_CW | Vertical back porch, lines |
| cfg_hs_pos_i | input | 1 | 1 = hsync active high |
| cfg_vs_pos_i | input | 1 | 1 = vsync active high |
| cfg_right_i | input | 1 | 1 = this instance drives the right half |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Display-enable, active high |
| col_o | output | clog2(HACT) | Pixel-pair column within the half |
| line_o | output | clog2(VACT) | Active line number |
| pix_o | output | clog2(4*HACT) | Absolute index of the even pixel |
| right_o | output | 1 | Half flag in use this frame |

## Verification
On the last clock of a frame, three things happen together: the shadow register reloads, the horizontal counter wraps and the vertical counter wraps. The new widths must take effect on exactly the next clock and at no other point. The bench provokes this by changing the inputs in the middle of a frame, and by giving illegal sets that must fall back. It then compares every output of every cycle across the boundary with a frame model built from the effective set that the bench itself derives. The second overlap is the vsync update point within a line whose horizontal sync has just begun. It is judged by measuring, on the ports, the distance from each hsync leading edge to each vsync change.

// File: rtl/tg_pkg.sv
package tg_pkg;

    // width of every porch/sync configuration field
    localparam int TG_CW = 12;

    typedef logic [TG_CW-1:0] seg_t;

    typedef struct packed {
        seg_t fp;
        seg_t sw;
        seg_t bp;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        logic      hs_pos;
        logic      vs_pos;
        logic      right;
    } frame_cfg_t;

endpackage

// File: rtl/tg_cfg_shadow.sv
module tg_cfg_shadow
    import tg_pkg::*;
#(
    parameter int HACT       = 512,
    parameter int H_FP_DEF   = 12,
    parameter int H_SW_DEF   = 68,
    parameter int H_BP_DEF   = 80,
    parameter int V_FP_DEF   = 6,
    parameter int V_SW_DEF   = 12,
    parameter int V_BP_DEF   = 58,
    parameter int HBLANK_MIN = 128,
    parameter int HBLANK_MAX = 188,
    parameter int HTOTAL_MIN = 640,
    parameter int HTOTAL_MAX = 700,
    parameter int VBLANK_MIN = 11,
    parameter int VBLANK_MAX = 92,
    parameter int VS_ALIGN   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_end_i,
    input  frame_cfg_t raw_i,
    output frame_cfg_t cfg_o
);

    localparam axis_cfg_t H_DEF = '{fp: seg_t'(H_FP_DEF), sw: seg_t'(H_SW_DEF), bp: seg_t'(H_BP_DEF)};
    localparam axis_cfg_t V_DEF = '{fp: seg_t'(V_FP_DEF), sw: seg_t'(V_SW_DEF), bp: seg_t'(V_BP_DEF)};
    localparam frame_cfg_t CFG_DEF = '{h: H_DEF, v: V_DEF, hs_pos: 1'b1, vs_pos: 1'b1, right: 1'b0};

    frame_cfg_t cfg_d, cfg_q;
    logic       h_ok, v_ok;
    int         h_blank, h_total, v_blank, hq_blank;

    // legality of the raw sets
    always_comb begin
        h_blank = int'(raw_i.h.fp) + int'(raw_i.h.sw) + int'(raw_i.h.bp);
        h_total = h_blank + HACT;
        v_blank = int'(raw_i.v.fp) + int'(raw_i.v.sw) + int'(raw_i.v.bp);
        h_ok = (raw_i.h.fp != '0) && (raw_i.h.sw != '0) && (raw_i.h.bp != '0)
            && (h_blank >= HBLANK_MIN) && (h_blank <= HBLANK_MAX)
            && (h_total >= HTOTAL_MIN) && (h_total <= HTOTAL_MAX)
            && (int'(raw_i.h.fp) + VS_ALIGN < h_total);
        v_ok = (raw_i.v.fp != '0) && (raw_i.v.sw != '0) && (raw_i.v.bp != '0)
            && (v_blank >= VBLANK_MIN) && (v_blank <= VBLANK_MAX);
    end

    // next state
    always_comb begin
        cfg_d = cfg_q;
        if (frame_end_i) begin
            cfg_d.h      = h_ok ? raw_i.h : H_DEF;
            cfg_d.v      = v_ok ? raw_i.v : V_DEF;
            cfg_d.hs_pos = raw_i.hs_pos;
            cfg_d.vs_pos = raw_i.vs_pos;
            cfg_d.right  = raw_i.right;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_DEF;
        else     cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    assign hq_blank = int'(cfg_q.h.fp) + int'(cfg_q.h.sw) + int'(cfg_q.h.bp);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_end_i |=> $stable(cfg_q)); // R7
    AST_HBLANK_LEGAL: assert property (@(posedge clk) disable iff (rst)
        frame_end_i |=> (hq_blank >= HBLANK_MIN && hq_blank <= HBLANK_MAX)); // R8

endmodule

// File: rtl/tg_axis_counter.sv
module tg_axis_counter
    import tg_pkg::*;
#(
    parameter int ACTIVE = 512,
    parameter int CNT_W  = 14,
    parameter int IDX_W  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  axis_cfg_t        seg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             sync_o,
    output logic             act_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic [CNT_W-1:0] sync_beg, sync_end, blank, total;
    logic             last;

    always_comb begin
        sync_beg = CNT_W'(seg_i.fp);
        sync_end = sync_beg + CNT_W'(seg_i.sw);
        blank    = sync_end + CNT_W'(seg_i.bp);
        total    = blank + CNT_W'(ACTIVE);
        last     = (st_q.cnt == total - CNT_W'(1));
        st_d     = st_q;
        if (step_i) st_d.cnt = last ? '0 : st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = step_i & last;
    assign sync_o = (st_q.cnt >= sync_beg) && (st_q.cnt < sync_end);
    assign act_o  = (st_q.cnt >= blank);
    assign idx_o  = act_o ? IDX_W'(st_q.cnt - blank) : '0;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (st_q.cnt == '0)); // R2
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(st_q.cnt)); // R3
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt < total)); // R2

endmodule

// File: rtl/tg_vsync_align.sv
module tg_vsync_align
    import tg_pkg::*;
#(
    parameter int VS_ALIGN = 16,
    parameter int VS_GUARD = 6,
    parameter int CNT_W    = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] h_cnt_i,
    input  seg_t             h_fp_i,
    input  logic             hs_act_i,
    input  logic             v_sync_i,
    output logic             vs_act_o
);

    localparam int DW = $clog2(VS_ALIGN + VS_GUARD + 2) + 1;
    localparam logic [DW-1:0] SAT = {DW{1'b1}};

    typedef struct packed {
        logic          vs;
        logic          vs_prev;
        logic          hs_prev;
        logic [DW-1:0] since_hs;
        logic [DW-1:0] since_vs;
    } va_t;

    va_t           st_d, st_q;
    logic          align_hit, hs_lead, vs_chg;
    logic [DW-1:0] dist_hs, dist_vs;

    always_comb begin
        // the vsync register loads one clock before the alignment point
        align_hit = (h_cnt_i == CNT_W'(h_fp_i) + CNT_W'(VS_ALIGN - 1));
        hs_lead   = hs_act_i & ~st_q.hs_prev;
        vs_chg    = st_q.vs ^ st_q.vs_prev;
        dist_hs   = hs_lead ? '0 : st_q.since_hs;
        dist_vs   = vs_chg ? '0 : st_q.since_vs;

        st_d          = st_q;
        st_d.vs       = align_hit ? v_sync_i : st_q.vs;
        st_d.vs_prev  = st_q.vs;
        st_d.hs_prev  = hs_act_i;
        st_d.since_hs = (dist_hs == SAT) ? SAT : dist_hs + DW'(1);
        st_d.since_vs = (dist_vs == SAT) ? SAT : dist_vs + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.since_hs <= SAT;
            st_q.since_vs <= SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign vs_act_o = st_q.vs;

    AST_VS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        vs_chg |-> (dist_hs == DW'(VS_ALIGN))); // R10
    AST_VS_CLEAR_AFTER: assert property (@(posedge clk) disable iff (rst)
        vs_chg |-> (dist_hs > DW'(VS_GUARD))); // R10
    AST_VS_CLEAR_BEFORE: assert property (@(posedge clk) disable iff (rst)
        hs_lead |-> (dist_vs > DW'(VS_GUARD))); // R10

endmodule

// File: rtl/halfscreen_timing.sv
module halfscreen_timing
    import tg_pkg::*;
#(
    parameter int HACT       = 512,
    parameter int VACT       = 1536,
    parameter int H_FP_DEF   = 12,
    parameter int H_SW_DEF   = 68,
    parameter int H_BP_DEF   = 80,
    parameter int V_FP_DEF   = 6,
    parameter int V_SW_DEF   = 12,
    parameter int V_BP_DEF   = 58,
    parameter int HBLANK_MIN = 128,
    parameter int HBLANK_MAX = 188,
    parameter int HTOTAL_MIN = 640,
    parameter int HTOTAL_MAX = 700,
    parameter int VBLANK_MIN = 11,
    parameter int VBLANK_MAX = 92,
    parameter int VS_ALIGN   = 16,
    parameter int VS_GUARD   = 6,
    localparam int COL_W     = $clog2(HACT),
    localparam int LINE_W    = $clog2(VACT),
    localparam int PIX_W     = $clog2(4 * HACT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TG_CW-1:0]  cfg_hfp_i,
    input  logic [TG_CW-1:0]  cfg_hsw_i,
    input  logic [TG_CW-1:0]  cfg_hbp_i,
    input  logic [TG_CW-1:0]  cfg_vfp_i,
    input  logic [TG_CW-1:0]  cfg_vsw_i,
    input  logic [TG_CW-1:0]  cfg_vbp_i,
    input  logic              cfg_hs_pos_i,
    input  logic              cfg_vs_pos_i,
    input  logic              cfg_right_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [COL_W-1:0]  col_o,
    output logic [LINE_W-1:0] line_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              right_o
);

    localparam int HC_W = $clog2(HACT + 3 * (2 ** TG_CW));
    localparam int VC_W = $clog2(VACT + 3 * (2 ** TG_CW));

    frame_cfg_t        raw, cfg;
    logic [HC_W-1:0]   h_cnt;
    logic [VC_W-1:0]   v_cnt;
    logic              h_wrap, v_wrap, h_sync, v_sync, h_act, v_act, vs_act;
    logic              frame_end;
    logic [COL_W-1:0]  h_idx;
    logic [LINE_W-1:0] v_idx;

    always_comb begin
        raw.h.fp  = cfg_hfp_i;
        raw.h.sw  = cfg_hsw_i;
        raw.h.bp  = cfg_hbp_i;
        raw.v.fp  = cfg_vfp_i;
        raw.v.sw  = cfg_vsw_i;
        raw.v.bp  = cfg_vbp_i;
        raw.hs_pos = cfg_hs_pos_i;
        raw.vs_pos = cfg_vs_pos_i;
        raw.right  = cfg_right_i;
    end

    assign frame_end = h_wrap & v_wrap;

    tg_cfg_shadow #(
        .HACT(HACT), .H_FP_DEF(H_FP_DEF), .H_SW_DEF(H_SW_DEF), .H_BP_DEF(H_BP_DEF),
        .V_FP_DEF(V_FP_DEF), .V_SW_DEF(V_SW_DEF), .V_BP_DEF(V_BP_DEF),
        .HBLANK_MIN(HBLANK_MIN), .HBLANK_MAX(HBLANK_MAX),
        .HTOTAL_MIN(HTOTAL_MIN), .HTOTAL_MAX(HTOTAL_MAX),
        .VBLANK_MIN(VBLANK_MIN), .VBLANK_MAX(VBLANK_MAX), .VS_ALIGN(VS_ALIGN)
    ) u_shadow (
        .clk(clk), .rst(rst), .frame_end_i(frame_end), .raw_i(raw), .cfg_o(cfg)
    );

    tg_axis_counter #(.ACTIVE(HACT), .CNT_W(HC_W), .IDX_W(COL_W)) u_hctr (
        .clk(clk), .rst(rst), .step_i(1'b1), .seg_i(cfg.h),
        .cnt_o(h_cnt), .wrap_o(h_wrap), .sync_o(h_sync), .act_o(h_act), .idx_o(h_idx)
    );

    tg_axis_counter #(.ACTIVE(VACT), .CNT_W(VC_W), .IDX_W(LINE_W)) u_vctr (
        .clk(clk), .rst(rst), .step_i(h_wrap), .seg_i(cfg.v),
        .cnt_o(v_cnt), .wrap_o(v_wrap), .sync_o(v_sync), .act_o(v_act), .idx_o(v_idx)
    );

    tg_vsync_align #(.VS_ALIGN(VS_ALIGN), .VS_GUARD(VS_GUARD), .CNT_W(HC_W)) u_valign (
        .clk(clk), .rst(rst), .h_cnt_i(h_cnt), .h_fp_i(cfg.h.fp),
        .hs_act_i(h_sync), .v_sync_i(v_sync), .vs_act_o(vs_act)
    );

    always_comb begin
        hsync_o = cfg.hs_pos ? h_sync : ~h_sync;
        vsync_o = cfg.vs_pos ? vs_act : ~vs_act;
        de_o    = h_act & v_act;
        col_o   = de_o ? h_idx : '0;
        line_o  = de_o ? v_idx : '0;
        pix_o   = de_o ? ((cfg.right ? PIX_W'(2 * HACT) : '0) + {PIX_W'(h_idx), 1'b0}) : '0;
        right_o = cfg.right;
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (h_cnt == '0 && v_cnt == '0)); // R3
    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (de_o && col_o != COL_W'(HACT - 1)) |=> (de_o && col_o == $past(col_o) + COL_W'(1))); // R4
    AST_HALF_STEADY: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(right_o)); // R5

endmodule

// File: tb/sim_halfscreen_timing.sv
module sim_halfscreen_timing;
    import tg_pkg::*;

    localparam int HACT = 16, VACT = 4;
    localparam int HFD = 2, HSD = 3, HBD = 4, VFD = 1, VSD = 2, VBD = 1;
    localparam int HBMIN = 6, HBMAX = 12, HTMIN = 22, HTMAX = 28;
    localparam int VBMIN = 3, VBMAX = 8, ALIGN = 4, GUARD = 2;
    localparam int COLW = $clog2(HACT), LINEW = $clog2(VACT), PIXW = $clog2(4 * HACT);

    typedef struct {
        int hfp, hsw, hbp, vfp, vsw, vbp;
        bit hpos, vpos, right;
    } tcfg_t;

    logic clk = 1'b0, rst = 1'b1;
    logic [TG_CW-1:0] hfp_i, hsw_i, hbp_i, vfp_i, vsw_i, vbp_i;
    logic hpos_i, vpos_i, right_i;
    logic hsync, vsync, de, right;
    logic [COLW-1:0]  col;
    logic [LINEW-1:0] line;
    logic [PIXW-1:0]  pix;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    halfscreen_timing #(
        .HACT(HACT), .VACT(VACT), .H_FP_DEF(HFD), .H_SW_DEF(HSD), .H_BP_DEF(HBD),
        .V_FP_DEF(VFD), .V_SW_DEF(VSD), .V_BP_DEF(VBD),
        .HBLANK_MIN(HBMIN), .HBLANK_MAX(HBMAX), .HTOTAL_MIN(HTMIN), .HTOTAL_MAX(HTMAX),
        .VBLANK_MIN(VBMIN), .VBLANK_MAX(VBMAX), .VS_ALIGN(ALIGN), .VS_GUARD(GUARD)
    ) u0 (
        .clk(clk), .rst(rst),
        .cfg_hfp_i(hfp_i), .cfg_hsw_i(hsw_i), .cfg_hbp_i(hbp_i),
        .cfg_vfp_i(vfp_i), .cfg_vsw_i(vsw_i), .cfg_vbp_i(vbp_i),
        .cfg_hs_pos_i(hpos_i), .cfg_vs_pos_i(vpos_i), .cfg_right_i(right_i),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .col_o(col), .line_o(line),
        .pix_o(pix), .right_o(right)
    );

    function automatic tcfg_t mk(int a, int b, int c, int d, int e, int f, bit hp, bit vp, bit rt);
        tcfg_t t;
        t.hfp = a; t.hsw = b; t.hbp = c; t.vfp = d; t.vsw = e; t.vbp = f;
        t.hpos = hp; t.vpos = vp; t.right = rt;
        return t;
    endfunction

    // effective set per R8 / R9
    function automatic tcfg_t eff(tcfg_t r);
        tcfg_t e = r;
        int hb = r.hfp + r.hsw + r.hbp;
        int vb = r.vfp + r.vsw + r.vbp;
        if (!(r.hfp >= 1 && r.hsw >= 1 && r.hbp >= 1 && hb >= HBMIN && hb <= HBMAX &&
              hb + HACT >= HTMIN && hb + HACT <= HTMAX && r.hfp + ALIGN < hb + HACT)) begin
            e.hfp = HFD; e.hsw = HSD; e.hbp = HBD;
        end
        if (!(r.vfp >= 1 && r.vsw >= 1 && r.vbp >= 1 && vb >= VBMIN && vb <= VBMAX)) begin
            e.vfp = VFD; e.vsw = VSD; e.vbp = VBD;
        end
        return e;
    endfunction

    function automatic int frame_len(tcfg_t c);
        return (c.hfp + c.hsw + c.hbp + HACT) * (c.vfp + c.vsw + c.vbp + VACT);
    endfunction

    task automatic drive(tcfg_t c);
        hfp_i = TG_CW'(c.hfp); hsw_i = TG_CW'(c.hsw); hbp_i = TG_CW'(c.hbp);
        vfp_i = TG_CW'(c.vfp); vsw_i = TG_CW'(c.vsw); vbp_i = TG_CW'(c.vbp);
        hpos_i = c.hpos; vpos_i = c.vpos; right_i = c.right;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk(string tag, string what, int got, int exp, int j);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d (cycle %0d of frame)", tag, what, got, exp, j);
        end
    endtask

    // compare all outputs with the frame model at cycle j of a frame timed by c
    task automatic compare(string tag, tcfg_t c, int j);
        int ht = c.hfp + c.hsw + c.hbp + HACT;
        int hb = c.hfp + c.hsw + c.hbp;
        int vb = c.vfp + c.vsw + c.vbp;
        int h = j % ht, v = j / ht;
        int vl = (h >= c.hfp + ALIGN) ? v : v - 1;
        bit hsa = (h >= c.hfp) && (h < c.hfp + c.hsw);
        bit vsa = (vl >= c.vfp) && (vl < c.vfp + c.vsw);
        bit e_de = (h >= hb) && (v >= vb);
        int e_col = e_de ? h - hb : 0;
        int e_line = e_de ? v - vb : 0;
        int e_pix = e_de ? (c.right ? 2 * HACT : 0) + 2 * e_col : 0;
        chk(tag, "hsync", int'(hsync), int'(c.hpos ? hsa : !hsa), j);
        chk(tag, "vsync", int'(vsync), int'(c.vpos ? vsa : !vsa), j);
        chk(tag, "de", int'(de), int'(e_de), j);
        chk(tag, "col", int'(col), e_col, j);
        chk(tag, "line", int'(line), e_line, j);
        chk(tag, "pix", int'(pix), e_pix, j);
        chk(tag, "right", int'(right), int'(c.right), j);
    endtask

    // starts right after reset release; optional input change at cycle chg_at
    task automatic run(string tag, tcfg_t f1, tcfg_t f2, tcfg_t f3, int nfr, int chg_at, tcfg_t nin);
        int g = 0;
        for (int f = 0; f < nfr; f++) begin
            tcfg_t c = (f == 0) ? f1 : ((f == 1) ? f2 : f3);
            for (int j = 0; j < frame_len(c); j++) begin
                compare(tag, c, j);
                if (g == chg_at) drive(nin);
                g++;
                @(negedge clk);
            end
        end
    endtask

    tcfg_t DEF, C, C2, CP, BH, BH2, BV, BV2;

    task automatic test_reset();
        drive(C);
        do_reset();
        // R1: outputs in the first cycle after reset, defaults in force
        chk("R1", "de", int'(de), 0, 0);
        chk("R1", "hsync", int'(hsync), 0, 0);
        chk("R1", "vsync", int'(vsync), 0, 0);
        chk("R1", "col", int'(col), 0, 0);
        chk("R1", "line", int'(line), 0, 0);
        chk("R1", "pix", int'(pix), 0, 0);
        chk("R1", "right", int'(right), 0, 0);
        run("R1 first frame", DEF, DEF, DEF, 1, -1, DEF);
    endtask

    task automatic test_default();
        drive(DEF);
        do_reset();
        run("R2 R3 R4 R11", DEF, DEF, DEF, 2, -1, DEF);
    endtask

    task automatic test_custom();
        drive(C);
        do_reset();
        run("R5 R6", DEF, eff(C), eff(C), 3, -1, C);
    endtask

    task automatic test_bad_h();
        drive(BH);
        do_reset();
        run("R8 blank", DEF, eff(BH), eff(BH), 2, -1, BH);
        drive(BH2);
        do_reset();
        run("R8 zero", DEF, eff(BH2), eff(BH2), 2, -1, BH2);
    endtask

    task automatic test_bad_v();
        drive(BV);
        do_reset();
        run("R9 zero", DEF, eff(BV), eff(BV), 2, -1, BV);
        drive(BV2);
        do_reset();
        run("R9 blank", DEF, eff(BV2), eff(BV2), 2, -1, BV2);
    endtask

    task automatic test_midframe();
        drive(C);
        do_reset();
        // R7: change lands mid-way through frame 2 and must wait for frame 3
        run("R7", DEF, eff(C), eff(C2), 3, frame_len(DEF) + 30, C2);
    endtask

    task automatic test_vs_spacing();
        int lead = -1000, n = 0, total;
        bit ph, pv;
        drive(CP);
        do_reset();
        total = frame_len(DEF) + 2 * frame_len(eff(CP));
        ph = hsync; pv = vsync;
        for (int j = 1; j < total; j++) begin
            @(negedge clk);
            if (hsync && !ph) lead = j;
            if (vsync != pv) begin
                n++;
                chk("R10", "vsync distance from hsync lead", j - lead, ALIGN, j);
            end
            ph = hsync; pv = vsync;
        end
        chk("R10", "vsync change count", n, 6, total);
    endtask

    initial begin
        DEF = mk(HFD, HSD, HBD, VFD, VSD, VBD, 1, 1, 0);
        C   = mk(3, 2, 2, 2, 1, 2, 0, 0, 1);
        C2  = mk(1, 4, 6, 1, 1, 1, 1, 0, 0);
        CP  = mk(3, 2, 2, 2, 1, 2, 1, 1, 0);
        BH  = mk(5, 5, 5, 2, 1, 2, 0, 1, 1);
        BH2 = mk(3, 0, 4, 2, 1, 2, 1, 1, 0);
        BV  = mk(3, 2, 2, 2, 0, 2, 1, 0, 0);
        BV2 = mk(3, 2, 2, 5, 5, 5, 1, 1, 1);
        drive(DEF);
        test_reset();
        test_default();
        test_custom();
        test_bad_h();
        test_bad_v();
        test_midframe();
        test_vs_spacing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule